// File: doc/BRIEF.md
# Single-Wire Pulse-Count Command Decoder

This block turns a single control pin into a small command channel. A host drives the pin high to wake the block, which raises an enable flag. It then sends bursts of short low-high pulses and leaves the pin high afterwards. Once the pin has been steady high for a long window, the number of rising edges in the burst is taken as a command. The command either selects a 5-bit code for the negative supply rail or sets a discharge option. Holding the pin low for the same long window is a shutdown request. Shutdown clears the enable flag and returns the code and the discharge option to their defaults.

The pin passes through a two-flop synchronizer and a glitch filter before any edge is counted. After each accepted command there is a blackout window, and edges that arrive during it are ignored. Every timing window is a cycle count set by a parameter of the system clock. The defaults at 125 MHz are about 1 µs for the filter, 350 µs for the long level and 10 ms for the blackout.

Top module: `pulse_cmd_decoder`

## Requirements
- R1: A level change on `line_i` that lasts fewer than FILT_CYC clock cycles, after the two-flop synchronizer, has no effect on any output.
- R2: A completed burst of n rising edges, with 1 <= n <= 20, sets `vneg_code_o` to n-1. Code 0 is -2.4 V (the default), code k is -2.4 V + k·0.1 V for k up to 18 (-0.6 V), and code 19 is 0 V.
- R3: A completed burst of exactly 21 edges sets `dis_en_o` and leaves `vneg_code_o` unchanged. `dis_en_o` then stays set through later commands until shutdown.
- R4: A completed burst of 22 or more edges leaves the code and `dis_en_o` unchanged and pulses `cmd_err_o` high for one cycle. `cmd_vld_o` stays low.
- R5: When the filtered line has stayed low for STOP_CYC cycles, `en_o` clears, `vneg_code_o` returns to 0 and `dis_en_o` clears.
- R6: While `en_o` is low, a filtered rising edge sets `en_o`. That wake edge is not counted as a pulse.
- R7: A burst ends once the filtered line has stayed high for STOP_CYC cycles after its last rising edge. A valid command (R2, R3) then pulses `cmd_vld_o` high for one cycle. No strobe occurs while `en_o` is low.
- R8: For WAIT_CYC cycles after a burst ends, rising edges are ignored. A burst sent inside that window changes no output.
- R9: After reset, `en_o`, `dis_en_o`, `cmd_vld_o` and `cmd_err_o` are 0 and `vneg_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous single-wire control line |
| en_o | output | 1 | Block enabled (line woken, no shutdown since) |
| vneg_code_o | output | 5 | Negative-rail voltage code (0 = -2.4 V, 19 = 0 V) |
| dis_en_o | output | 1 | Sticky output-discharge enable |
| cmd_vld_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_err_o | output | 1 | One-cycle strobe for an out-of-range count |

## Verification
The bench goes after the count boundaries, which are 1, 20, 21 and 23 edges. An off-by-one in edge counting would shift every code, and a wrong range test would turn the discharge command into a voltage change or let an invalid count through. A short glitch is sent while the block is asleep and another inside a burst. A filter that was too weak would wake the block or count an extra pulse. A second burst is sent inside the blackout window, and a design without the window would latch it. A long low is sent with the discharge flag set, which catches a shutdown that fails to restore the default code or to clear the sticky flag.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_HOLD = 2'd2
  } ctl_state_t;

  localparam int CODE_W       = 5;
  localparam int MAX_VOLT_CNT = 20;
  localparam int DIS_CNT      = 21;
  localparam int MAX_CODE     = MAX_VOLT_CNT - 1;
endpackage

// File: rtl/pcd_line_filter.sv
module pcd_line_filter #(
  parameter int FILT_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o
);
  localparam int FW = (FILT_CYC > 1) ? $clog2(FILT_CYC + 1) : 1;

  logic          sync1_q, sync2_q;
  logic          lvl_q, lvl_d;
  logic [FW-1:0] fcnt_q, fcnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    lvl_d  = lvl_q;
    fcnt_d = fcnt_q;
    if (sync2_q == lvl_q) begin
      fcnt_d = '0;
    end else if (fcnt_q == FW'(FILT_CYC - 1)) begin
      lvl_d  = sync2_q;
      fcnt_d = '0;
    end else begin
      fcnt_d = fcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      fcnt_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/pcd_run_timer.sv
module pcd_run_timer #(
  parameter int STOP_CYC = 43750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic long_hi_o,
  output logic long_lo_o
);
  localparam int RW = $clog2(STOP_CYC + 1);

  logic          lvl_q;
  logic [RW-1:0] run_q, run_d;
  logic          same, tick;

  assign same = (level_i == lvl_q);
  assign tick = same && (run_q == RW'(STOP_CYC - 1));

  always_comb begin
    run_d = run_q;
    if (!same)
      run_d = '0;
    else if (run_q != RW'(STOP_CYC))
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= level_i;
      run_q <= run_d;
    end
  end

  assign rise_o    = level_i & ~lvl_q;
  assign long_hi_o = tick & level_i;
  assign long_lo_o = tick & ~level_i;

  p_long_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    long_hi_o |=> !long_hi_o);
endmodule

// File: rtl/pcd_cmd_fsm.sv
module pcd_cmd_fsm
  import pcd_pkg::*;
#(
  parameter int WAIT_CYC = 1250000,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              long_hi_i,
  input  logic              long_lo_i,
  output logic              en_o,
  output logic [CODE_W-1:0] code_o,
  output logic              dis_o,
  output logic              vld_o,
  output logic              err_o
);
  localparam int WW = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  ctl_state_t        st_q, st_d;
  logic [CNT_W-1:0]  pcnt_q, pcnt_d;
  logic [WW-1:0]     wcnt_q, wcnt_d;
  logic              en_q, en_d, dis_q, dis_d, vld_q, vld_d, err_q, err_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    wcnt_d = wcnt_q;
    en_d   = en_q;
    dis_d  = dis_q;
    code_d = code_q;
    vld_d  = 1'b0;
    err_d  = 1'b0;
    if (long_lo_i) begin
      st_d   = ST_OFF;
      en_d   = 1'b0;
      dis_d  = 1'b0;
      code_d = '0;
      pcnt_d = '0;
      wcnt_d = '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          if (rise_i) begin
            en_d   = 1'b1;
            pcnt_d = '0;
            st_d   = ST_ON;
          end
        end
        ST_ON: begin
          if (rise_i) begin
            if (pcnt_q != CNT_SAT) pcnt_d = pcnt_q + 1'b1;
          end else if (long_hi_i && (pcnt_q != '0)) begin
            if (pcnt_q <= CNT_W'(MAX_VOLT_CNT)) begin
              code_d = CODE_W'(pcnt_q - 1'b1);
              vld_d  = 1'b1;
            end else if (pcnt_q == CNT_W'(DIS_CNT)) begin
              dis_d = 1'b1;
              vld_d = 1'b1;
            end else begin
              err_d = 1'b1;
            end
            pcnt_d = '0;
            wcnt_d = '0;
            st_d   = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (wcnt_q == WW'(WAIT_CYC - 1)) st_d = ST_ON;
          else wcnt_d = wcnt_q + 1'b1;
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      pcnt_q <= '0;
      wcnt_q <= '0;
      en_q   <= 1'b0;
      dis_q  <= 1'b0;
      code_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      wcnt_q <= wcnt_d;
      en_q   <= en_d;
      dis_q  <= dis_d;
      code_q <= code_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  assign en_o   = en_q;
  assign code_o = code_q;
  assign dis_o  = dis_q;
  assign vld_o  = vld_q;
  assign err_o  = err_q;

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= CODE_W'(MAX_CODE));
  p_dis_falls_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dis_q) |-> !en_q);
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && err_q));
  p_shutdown_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> (code_q == '0 && !dis_q));
  p_vld_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> en_q);
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q || err_q) |=> !(vld_q || err_q));
endmodule

// File: rtl/pulse_cmd_decoder.sv
module pulse_cmd_decoder
  import pcd_pkg::*;
#(
  parameter int FILT_CYC = 125,
  parameter int STOP_CYC = 43750,
  parameter int WAIT_CYC = 1250000,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              en_o,
  output logic [CODE_W-1:0] vneg_code_o,
  output logic              dis_en_o,
  output logic              cmd_vld_o,
  output logic              cmd_err_o
);
  logic rst_s1_q, rst_s2_q;
  logic level, rise, long_hi, long_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  pcd_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_s2_q), .line_i(line_i), .level_o(level)
  );

  pcd_run_timer #(.STOP_CYC(STOP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_s2_q), .level_i(level),
    .rise_o(rise), .long_hi_o(long_hi), .long_lo_o(long_lo)
  );

  pcd_cmd_fsm #(.WAIT_CYC(WAIT_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_s2_q),
    .rise_i(rise), .long_hi_i(long_hi), .long_lo_i(long_lo),
    .en_o(en_o), .code_o(vneg_code_o), .dis_o(dis_en_o),
    .vld_o(cmd_vld_o), .err_o(cmd_err_o)
  );
endmodule

// File: tb/pulse_cmd_decoder_tb_top.sv
module pulse_cmd_decoder_tb_top;
  localparam int FILT = 4;
  localparam int STOP = 200;
  localparam int WAITC = 800;
  localparam int HALF = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic       en, dis, vld, err;
  logic [4:0] code;

  int n_cmp = 0;
  int n_bad = 0;
  int n_vld = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pulse_cmd_decoder #(.FILT_CYC(FILT), .STOP_CYC(STOP), .WAIT_CYC(WAITC)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .en_o(en), .vneg_code_o(code),
    .dis_en_o(dis), .cmd_vld_o(vld), .cmd_err_o(err)
  );

  // behavioural reference model
  int m_rc = 0;
  int m_s1 = 0, m_s2 = 0, m_flt = 0, m_fc = 0, m_lq = 0, m_run = 0;
  int m_st = 0, m_pc = 0, m_wc = 0, m_en = 0, m_dis = 0, m_code = 0, m_vld = 0, m_err = 0;

  always @(posedge clk or negedge rst_n) begin
    int s1, s2, flt, fc, lq, run, st, pc, wc, e, d, c, v, r;
    bit rise, hi, lo, same;
    if (!rst_n) m_rc = 0;
    else if (m_rc < 3) m_rc = m_rc + 1;
    if (!rst_n || m_rc < 3) begin
      m_s1 = 0; m_s2 = 0; m_flt = 0; m_fc = 0; m_lq = 0; m_run = 0;
      m_st = 0; m_pc = 0; m_wc = 0; m_en = 0; m_dis = 0; m_code = 0; m_vld = 0; m_err = 0;
      if (rst_n) begin m_s1 = int'(line); m_s2 = 0; end
      if (m_rc < 2) begin m_s1 = (m_rc == 0) ? 0 : m_s1; end
    end else begin
      s1 = int'(line); s2 = m_s1;
      flt = m_flt; fc = m_fc;
      if (m_s2 == m_flt) fc = 0;
      else if (m_fc == FILT - 1) begin flt = m_s2; fc = 0; end
      else fc = m_fc + 1;
      same = (m_flt == m_lq);
      rise = (m_flt == 1) && (m_lq == 0);
      hi = same && (m_run == STOP - 1) && (m_flt == 1);
      lo = same && (m_run == STOP - 1) && (m_flt == 0);
      run = !same ? 0 : ((m_run != STOP) ? m_run + 1 : m_run);
      lq = m_flt;
      st = m_st; pc = m_pc; wc = m_wc; e = m_en; d = m_dis; c = m_code; v = 0; r = 0;
      if (lo) begin
        st = 0; e = 0; d = 0; c = 0; pc = 0; wc = 0;
      end else if (m_st == 0) begin
        if (rise) begin e = 1; pc = 0; st = 1; end
      end else if (m_st == 1) begin
        if (rise) begin if (m_pc < 31) pc = m_pc + 1; end
        else if (hi && m_pc != 0) begin
          if (m_pc <= 20) begin c = m_pc - 1; v = 1; end
          else if (m_pc == 21) begin d = 1; v = 1; end
          else r = 1;
          pc = 0; wc = 0; st = 2;
        end
      end else begin
        if (m_wc == WAITC - 1) st = 1; else wc = m_wc + 1;
      end
      m_s1 = s1; m_s2 = s2; m_flt = flt; m_fc = fc; m_lq = lq; m_run = run;
      m_st = st; m_pc = pc; m_wc = wc; m_en = e; m_dis = d; m_code = c; m_vld = v; m_err = r;
    end
  end

  task automatic cmp(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_rc >= 3) begin
      cmp("R6/R5 en", int'(en), m_en);
      cmp("R2 code", int'(code), m_code);
      cmp("R3 dis", int'(dis), m_dis);
      cmp("R7 vld", int'(vld), m_vld);
      cmp("R4 err", int'(err), m_err);
      if (vld) n_vld++;
      if (err) n_err++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(int n);
    for (int i = 0; i < n; i++) begin
      line = 1'b0; idle(HALF);
      line = 1'b1; idle(HALF);
    end
  endtask

  task automatic cmd(int n);
    burst(n);
    idle(STOP + 50);
  endtask

  initial begin
    int v0, e0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    // R9 reset state
    cmp("R9 en", int'(en), 0);
    cmp("R9 code", int'(code), 0);
    cmp("R9 dis", int'(dis), 0);
    cmp("R9 strobes", int'(vld | err), 0);
    // R1 short glitch while asleep
    line = 1'b1; idle(2); line = 1'b0; idle(30);
    cmp("R1 glitch no wake", int'(en), 0);
    // R6 wake
    line = 1'b1; idle(STOP + 50);
    cmp("R6 wake en", int'(en), 1);
    cmp("R6 wake not counted", n_vld, 0);
    // R2 counts
    cmd(5);   cmp("R2 count5", int'(code), 4); cmp("R7 strobe", n_vld, 1);
    idle(WAITC);
    cmd(20);  cmp("R2 count20", int'(code), 19);
    idle(WAITC);
    cmd(1);   cmp("R2 count1", int'(code), 0);
    idle(WAITC);
    cmd(12);  cmp("R2 count12", int'(code), 11);
    idle(WAITC);
    // R3 discharge
    cmd(21);  cmp("R3 dis set", int'(dis), 1); cmp("R3 code kept", int'(code), 11);
    idle(WAITC);
    // R4 invalid
    e0 = n_err; v0 = n_vld;
    cmd(23);
    cmp("R4 err strobe", n_err - e0, 1);
    cmp("R4 no vld", n_vld - v0, 0);
    cmp("R4 code kept", int'(code), 11);
    cmp("R4 dis kept", int'(dis), 1);
    idle(WAITC);
    cmd(3);   cmp("R3 dis sticky", int'(dis), 1); cmp("R2 count3", int'(code), 2);
    idle(WAITC);
    // R1 low glitch inside a burst
    burst(2);
    line = 1'b0; idle(2); line = 1'b1; idle(HALF);
    burst(2);
    idle(STOP + 50);
    cmp("R1 glitch not counted", int'(code), 3);
    idle(WAITC);
    // R8 blackout
    cmd(7);
    v0 = n_vld;
    cmd(10);
    cmp("R8 blackout code", int'(code), 6);
    cmp("R8 blackout strobe", n_vld - v0, 0);
    idle(WAITC);
    // R5 shutdown
    line = 1'b0; idle(STOP + 50);
    cmp("R5 en cleared", int'(en), 0);
    cmp("R5 code default", int'(code), 0);
    cmp("R5 dis cleared", int'(dis), 0);
    idle(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule